// File: doc/BRIEF.md
# Lookup-Table Population Counter

This block reports how many bits are set in an input word of up to 72 bits. The word is zero-extended to a whole number of 24-bit pairs and cut into 12-bit slices. Each slice addresses a fixed table whose entry at any address is the number of ones in that address. The tables are built as two-port read-only memories, so one memory answers two slices in the same clock. Three memories cover the full 72-bit width.

The table reads are registered and form the first pipeline stage. A small adder sums the 4-bit partial counts, and its result is registered as the second stage. A word presented with its valid strobe gives its count, with a matching valid strobe, exactly two clocks later. A new word may be accepted on every clock. The design aims at modest clock rates (tens of MHz) and favours area over speed.

Top module: `popcnt_lut_pipe`

The block has no state machine. The only sequencing is a valid bit that moves through the two pipeline registers: idle, slice-read, and result.

## Requirements
- R1: When `res_valid` is high, `res_count` equals the number of ones in the word that was accepted two clocks earlier.
- R2: The word is split into 12-bit slices. Each slice is turned into a partial count between 0 and 12 by a synchronous table read. The table entry at address a is the number of ones in a, and it is computed at elaboration without any file.
- R3: Each table memory serves two slices in the same clock through two independent read ports. The default 72-bit width uses three memories.
- R4: A word sampled with `word_valid` high at clock edge k produces `res_valid` high after edge k+2. At every other edge `res_valid` is low.
- R5: Words given on consecutive clocks give results on consecutive clocks, in the same order, and none is lost.
- R6: `res_count` is clog2(IN_W+1) bits wide. That is 7 bits for both 64 and 72 inputs. An all-ones 72-bit word gives 72.
- R7: When IN_W is less than 72, or is not a multiple of 24, the missing upper bits count as zero. With IN_W = 20, an all-ones word gives 20.
- R8: A synchronous reset (`rst` high) clears `res_valid` and `res_count` to 0 and drops any words still in the pipeline.
- R9: In a cycle with no new result, `res_count` keeps the last result (or 0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | Marks `word_in` as a word to count |
| word_in | input | IN_W | Word whose set bits are counted |
| res_valid | output | 1 | High for one cycle for each result |
| res_count | output | clog2(IN_W+1) | Number of set bits |

## Verification
Two functions can fall in the same clock. In a back-to-back stream, the adder stage emits one word's count while the table stage reads the next word. A reset can also land while words are still in flight. The scoreboard records the expected count and arrival cycle for every word it drives, including long unbroken streams, and compares each `res_valid` pulse against the head of the queue. It also asserts reset in the middle of a stream and then requires that no result from the dropped words ever appears.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;

    localparam int SLICE_W  = 12;
    localparam int PART_W   = 4;
    localparam int MAX_IN_W = 72;

    // Table contents: the entry at address a is the number of ones in a.
    function automatic logic [PART_W-1:0] slice_ones(input logic [SLICE_W-1:0] addr);
        logic [PART_W-1:0] n;
        n = '0;
        for (int i = 0; i < SLICE_W; i++) begin
            n = n + PART_W'(addr[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/popcnt_slice_rom.sv
module popcnt_slice_rom
    import popcnt_pkg::*;
(
    input  logic              clk,
    input  logic [SLICE_W-1:0] addr_a,
    input  logic [SLICE_W-1:0] addr_b,
    output logic [PART_W-1:0]  q_a,
    output logic [PART_W-1:0]  q_b
);

    // Two independent synchronous read ports on one constant table.
    // The table is a pure function of the address, so it is fixed at elaboration.
    always_ff @(posedge clk) begin
        q_a <= slice_ones(addr_a);
        q_b <= slice_ones(addr_b);
    end

endmodule

// File: rtl/popcnt_combine.sv
module popcnt_combine
    import popcnt_pkg::*;
#(
    parameter int NUM_PARTS = 6,
    parameter int CNT_W     = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        mid_valid,
    input  logic [NUM_PARTS*PART_W-1:0] parts,
    output logic                        res_valid,
    output logic [CNT_W-1:0]            res_count
);

    logic [CNT_W-1:0] total;
    logic             past_ok;

    always_comb begin
        total = '0;
        for (int i = 0; i < NUM_PARTS; i++) begin
            total = total + CNT_W'(parts[i*PART_W +: PART_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_count <= '0;
            past_ok   <= 1'b0;
        end else begin
            res_valid <= mid_valid;
            past_ok   <= 1'b1;
            if (mid_valid) begin
                res_count <= total;
            end
        end
    end

    // R9: the result holds whenever no partial counts arrived.
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(mid_valid)) |-> $stable(res_count));

endmodule

// File: rtl/popcnt_lut_pipe.sv
module popcnt_lut_pipe
    import popcnt_pkg::*;
#(
    parameter  int IN_W  = 72,
    localparam int CNT_W = $clog2(IN_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             word_valid,
    input  logic [IN_W-1:0]  word_in,
    output logic             res_valid,
    output logic [CNT_W-1:0] res_count
);

    localparam int NUM_SLICES = (IN_W + SLICE_W - 1) / SLICE_W;
    localparam int NUM_MEMS   = (NUM_SLICES + 1) / 2;
    localparam int NUM_PARTS  = NUM_MEMS * 2;
    localparam int PAD_W      = NUM_PARTS * SLICE_W;

    logic [PAD_W-1:0]            padded;
    logic [NUM_PARTS*PART_W-1:0] part_flat;
    logic                        mid_valid;
    logic [1:0]                  age;

    // R7: bits above IN_W are zero before slicing.
    assign padded = PAD_W'(word_in);

    // R2, R3: one two-port table per pair of slices.
    for (genvar m = 0; m < NUM_MEMS; m++) begin : g_mem
        popcnt_slice_rom u_rom (
            .clk    (clk),
            .addr_a (padded[(2*m)*SLICE_W +: SLICE_W]),
            .addr_b (padded[(2*m+1)*SLICE_W +: SLICE_W]),
            .q_a    (part_flat[(2*m)*PART_W +: PART_W]),
            .q_b    (part_flat[(2*m+1)*PART_W +: PART_W])
        );

        p_part_range_a_r2: assert property (@(posedge clk) disable iff (rst)
            (age != 2'd0 && mid_valid) |-> (part_flat[(2*m)*PART_W +: PART_W] <= PART_W'(SLICE_W)));
        p_part_range_b_r2: assert property (@(posedge clk) disable iff (rst)
            (age != 2'd0 && mid_valid) |-> (part_flat[(2*m+1)*PART_W +: PART_W] <= PART_W'(SLICE_W)));
    end

    // Valid flag for the table-read stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            mid_valid <= 1'b0;
            age       <= 2'd0;
        end else begin
            mid_valid <= word_valid;
            if (age != 2'd2) begin
                age <= age + 2'd1;
            end
        end
    end

    popcnt_combine #(
        .NUM_PARTS (NUM_PARTS),
        .CNT_W     (CNT_W)
    ) u_combine (
        .clk       (clk),
        .rst       (rst),
        .mid_valid (mid_valid),
        .parts     (part_flat),
        .res_valid (res_valid),
        .res_count (res_count)
    );

    // R4: a result appears exactly two clocks after its input strobe.
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (res_valid == $past(word_valid, 2)));

    // R1: table-based count agrees with a direct count of the input two clocks back.
    p_total_r1: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && res_valid) |->
            (32'(res_count) == 32'($past($countones(word_in), 2))));

    // R6: the count never exceeds the input width.
    p_count_range_r6: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && res_valid) |-> (32'(res_count) <= 32'(IN_W)));

endmodule

// File: tb/tb_popcnt_lut_pipe.sv
module tb_popcnt_lut_pipe;

    localparam int CLK_PERIOD = 10;
    localparam int W   = 72;
    localparam int CW  = $clog2(W + 1);
    localparam int W2  = 20;
    localparam int CW2 = $clog2(W2 + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           word_valid = 1'b0;
    logic [W-1:0]   word_in = '0;
    logic           res_valid;
    logic [CW-1:0]  res_count;
    logic           v2 = 1'b0;
    logic [W2-1:0]  d2 = '0;
    logic           rv2;
    logic [CW2-1:0] rc2;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_cnt = 0;
    int exp_cnt[$];
    int exp_cyc[$];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    popcnt_lut_pipe #(.IN_W(W)) dut (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word_in(word_in),
        .res_valid(res_valid), .res_count(res_count)
    );

    popcnt_lut_pipe #(.IN_W(W2)) dut_narrow (
        .clk(clk), .rst(rst), .word_valid(v2), .word_in(d2),
        .res_valid(rv2), .res_count(rc2)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [W-1:0] d);
        @(negedge clk);
        word_valid = 1'b1;
        word_in    = d;
        exp_cnt.push_back($countones(d));
        exp_cyc.push_back(cyc + 2);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            word_valid = 1'b0;
        end
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst) begin
            exp_cnt.delete();
            exp_cyc.delete();
            last_cnt = 0;
        end else if (res_valid) begin
            if (exp_cnt.size() == 0) begin
                check(1'b0, "R4", 1, 0, "result with no pending word");
            end else begin
                int e;
                int c;
                e = exp_cnt.pop_front();
                c = exp_cyc.pop_front();
                check(int'(res_count) == e, "R1", int'(res_count), e, "count");
                check(cyc == c, "R4", cyc, c, "arrival cycle");
                last_cnt = e;
            end
        end else begin
            check(int'(res_count) == last_cnt, "R9", int'(res_count), last_cnt, "held count");
            if (exp_cyc.size() > 0 && exp_cyc[0] <= cyc) begin
                check(1'b0, "R5", cyc, exp_cyc[0], "missing result");
                void'(exp_cyc.pop_front());
                void'(exp_cnt.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state.
        check(res_valid == 1'b0, "R8", int'(res_valid), 0, "valid after reset");
        check(res_count == '0, "R8", int'(res_count), 0, "count after reset");

        // R1, R6: directed patterns.
        push('0);
        idle(3);
        push({W{1'b1}});
        idle(3);
        push(W'(1) << 71);
        push(W'(1));
        push({36{2'b10}});
        push(W'(3) << 11);
        push(W'(12'hFFF) << 24);
        idle(4);

        // R5: long back-to-back stream of random words.
        for (int i = 0; i < 300; i++) begin
            push(W'({$urandom, $urandom, $urandom}));
        end
        idle(4);

        // Mixed gaps, exercising R9 hold between results.
        for (int i = 0; i < 100; i++) begin
            push(W'({$urandom, $urandom, $urandom}));
            idle($urandom_range(0, 3));
        end
        idle(4);
        check(exp_cnt.size() == 0, "R5", exp_cnt.size(), 0, "pending after stream");

        // R8: reset while words are in flight; none of them may surface.
        push({W{1'b1}});
        push(W'(5));
        @(negedge clk);
        word_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b0, "R8", int'(res_valid), 0, "valid after mid-stream reset");
        check(res_count == '0, "R8", int'(res_count), 0, "count after mid-stream reset");
        idle(4);

        // R7: narrow instance, all ones then a sparse pattern.
        @(negedge clk);
        v2 = 1'b1;
        d2 = '1;
        @(negedge clk);
        v2 = 1'b0;
        @(negedge clk);
        check(rv2 == 1'b1, "R7", int'(rv2), 1, "narrow valid");
        check(int'(rc2) == 20, "R7", int'(rc2), 20, "narrow all ones");
        @(negedge clk);
        check(rv2 == 1'b0, "R9", int'(rv2), 0, "narrow valid drops");
        check(int'(rc2) == 20, "R9", int'(rc2), 20, "narrow count holds");
        v2 = 1'b1;
        d2 = 20'h80F0F;
        @(negedge clk);
        v2 = 1'b0;
        @(negedge clk);
        check(int'(rc2) == 9, "R7", int'(rc2), 9, "narrow sparse");

        idle(3);
        check(exp_cnt.size() == 0, "R5", exp_cnt.size(), 0, "pending at end");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule